// File: doc/BRIEF.md
# Double-Buffered Quadrature NCO Mixer

This block tunes a real sample stream to baseband. A 32-bit phase accumulator advances by a frequency word on every clock. The upper part of the accumulator addresses a sine table, and cosine is read from the same table. Each incoming real sample is multiplied by the cosine to give the in-phase output and by the sine to give the quadrature output. Both products are rounded and saturated to the output width.

The frequency word is double-buffered. A host first writes the word into a pending register, and nothing changes in the running oscillator. A separate commit strobe then copies the pending word into the running register. An external sync pulse can also do this copy when sync commits are enabled. A phase-reset option sets the accumulator to zero on the commit edge, so that several instances that receive the same sync pulse restart from a common phase. The accumulator's phase word is also brought out, so a system can see or align the oscillator phase.

Top module: `quad_nco_mixer`

## Requirements
- R1: While `rst` is high at a clock edge, the pending word, the running word, the accumulator and every pipeline register are cleared. After reset, `phaseOut`, `iOut` and `qOut` read 0.
- R2: A word written with `freqWrEn` goes only into the pending register. Until a commit happens, the accumulator keeps stepping by the old running word.
- R3: A commit copies the pending word into the running word at that edge. If a write and a commit occur in the same cycle, the commit takes the pending value from before the write, and the new word stays pending.
- R4: `syncIn` commits only when `syncLoadEn` is 1. When `syncLoadEn` is 0, a sync pulse has no effect.
- R5: When `freqXfer` and an enabled `syncIn` are high in the same cycle, exactly one commit of the pending word takes place.
- R6: With `zeroOnLoad` at 1, the accumulator holds exactly 0 after the commit edge and then steps by the new word. With `zeroOnLoad` at 0, the accumulator continues from its value plus the old running word.
- R7: `phaseOut` is the top 24 bits of the 32-bit accumulator (accumulator bits 31 down to 8).
- R8: The sine amplitude for a table address a (the top `LUT_ADDR_W` bits of the phase word, with N = 2^LUT_ADDR_W entries) is round-half-away-from-zero of 262143·sin(2πa/N), a 19-bit signed value. The cosine is the same table read at address (a + N/4) mod N.
- R9: `iOut` = sat(floor((x·cos + 2^17) / 2^18)) and `qOut` = sat(floor((x·sin + 2^17) / 2^18)), where x is the signed 16-bit sample. The function sat clamps symmetrically to ±32767, so -32768 never appears.
- R10: A sample presented at clock edge k is combined with the table value for the accumulator value held just before edge k. The result appears on `iOut`/`qOut` after edge k+2, a latency of three register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freqWrEn | input | 1 | Load `freqWrData` into the pending frequency register |
| freqWrData | input | 32 | Frequency word to stage |
| freqXfer | input | 1 | Host commit strobe: pending word becomes the running word |
| syncIn | input | 1 | External sync pulse, commits when enabled |
| syncLoadEn | input | 1 | Allows `syncIn` to commit |
| zeroOnLoad | input | 1 | Sets the accumulator to zero on every commit |
| sampleIn | input | 16 | Signed real input sample |
| phaseOut | output | 24 | Truncated accumulator phase word |
| iOut | output | 16 | Signed in-phase product, rounded and saturated |
| qOut | output | 16 | Signed quadrature product, rounded and saturated |

## Verification
The mixer is driven with a frequency that steps exactly one table entry per clock, so that every table address is paired with each input pattern. The patterns are the two full-scale constants, a ramp, an alternating sign, and values of ±1. The full-scale constants separate symmetric saturation from plain wrap. The ±1 values and the ramp separate correct rounding from truncation. A second run uses an irregular frequency and pseudo-random samples, which exercises the phase truncation between table steps. A single isolated sample impulse pins down the latency. The commit logic is probed only through the phase step seen on `phaseOut`, under these conditions: a staged write without commit, a write and commit in the same cycle, a masked sync, an enabled sync, sync and host commit together, and both settings of the phase reset.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;
  // strobes from commit control to the oscillator datapath
  typedef struct packed {
    logic loadActive;
    logic zeroAcc;
  } ncoStrobe_t;
endpackage

// File: rtl/nco_mix_ctrl.sv
module nco_mix_ctrl
  import nco_mix_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freqWrEn,
  input  logic [FREQ_W-1:0] freqWrData,
  input  logic              freqXfer,
  input  logic              syncIn,
  input  logic              syncLoadEn,
  input  logic              zeroOnLoad,
  output logic [FREQ_W-1:0] activeFreq,
  output ncoStrobe_t        strobe
);
  logic [FREQ_W-1:0] holdFreq;
  logic              commitReq;

  // host strobe and enabled sync merge into one commit
  assign commitReq         = freqXfer | (syncIn & syncLoadEn);
  assign strobe.loadActive = commitReq;
  assign strobe.zeroAcc    = commitReq & zeroOnLoad;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdFreq   <= '0;
      activeFreq <= '0;
    end else begin
      if (freqWrEn)  holdFreq   <= freqWrData;
      if (commitReq) activeFreq <= holdFreq;
    end
  end

  assert_hold_only_on_write_R2: assert property (@(posedge clk) disable iff (rst)
    !freqWrEn |=> $stable(holdFreq));

  assert_commit_copies_R3: assert property (@(posedge clk) disable iff (rst)
    (freqXfer || (syncIn && syncLoadEn)) |=> activeFreq == $past(holdFreq));

  assert_masked_sync_R4: assert property (@(posedge clk) disable iff (rst)
    (!freqXfer && !syncLoadEn) |=> $stable(activeFreq));
endmodule

// File: rtl/nco_mix_datapath.sv
module nco_mix_datapath
  import nco_mix_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int PHASE_W    = 24,
  parameter int LUT_ADDR_W = 10,
  parameter int AMP_W      = 19,
  parameter int IN_W       = 16,
  parameter int OUT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [FREQ_W-1:0]       activeFreq,
  input  ncoStrobe_t              strobe,
  input  logic signed [IN_W-1:0]  sampleIn,
  output logic [PHASE_W-1:0]      phaseOut,
  output logic signed [OUT_W-1:0] iOut,
  output logic signed [OUT_W-1:0] qOut
);
  localparam int  LUT_N   = 1 << LUT_ADDR_W;
  localparam int  PROD_W  = IN_W + AMP_W;
  localparam int  FRAC    = AMP_W - 1;
  localparam int  SC_W    = PROD_W - FRAC + 1;
  localparam real AMP_MAX = 2.0 ** (AMP_W - 1) - 1.0;
  localparam int  OUT_MAX = (1 << (OUT_W - 1)) - 1;
  localparam logic signed [SC_W-1:0] SC_HI = SC_W'(OUT_MAX);
  localparam logic signed [SC_W-1:0] SC_LO = -SC_W'(OUT_MAX);

  // phase accumulator
  logic [FREQ_W-1:0] acc;
  always_ff @(posedge clk) begin
    if (rst)                 acc <= '0;
    else if (strobe.zeroAcc) acc <= '0;
    else                     acc <= acc + activeFreq;
  end
  assign phaseOut = acc[FREQ_W-1 -: PHASE_W];

  // sine table built at elaboration, cosine a quarter turn ahead
  logic signed [AMP_W-1:0] sinTab [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : g_tab
    localparam real ANG = 6.283185307179586 * k / LUT_N;
    localparam real SV  = AMP_MAX * $sin(ANG);
    localparam int  SI  = $rtoi(SV >= 0.0 ? SV + 0.5 : SV - 0.5);
    assign sinTab[k] = AMP_W'(SI);
  end

  logic [LUT_ADDR_W-1:0] sinAddr, cosAddr;
  assign sinAddr = phaseOut[PHASE_W-1 -: LUT_ADDR_W];
  assign cosAddr = sinAddr + LUT_ADDR_W'(LUT_N / 4);

  function automatic logic signed [OUT_W-1:0] roundSat(input logic signed [PROD_W-1:0] p);
    logic signed [PROD_W:0]  biased;
    logic signed [SC_W-1:0]  scaled;
    biased = {p[PROD_W-1], p} + (PROD_W + 1)'(1 << (FRAC - 1));
    scaled = biased[PROD_W:FRAC];
    if (scaled > SC_HI)      return SC_HI[OUT_W-1:0];
    else if (scaled < SC_LO) return SC_LO[OUT_W-1:0];
    else                     return scaled[OUT_W-1:0];
  endfunction

  // stage 1: lookup and sample capture; stage 2: multiply; stage 3: round
  logic signed [AMP_W-1:0]  sinReg, cosReg;
  logic signed [IN_W-1:0]   xReg;
  logic signed [PROD_W-1:0] prodI, prodQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinReg <= '0;
      cosReg <= '0;
      xReg   <= '0;
      prodI  <= '0;
      prodQ  <= '0;
      iOut   <= '0;
      qOut   <= '0;
    end else begin
      sinReg <= sinTab[sinAddr];
      cosReg <= sinTab[cosAddr];
      xReg   <= sampleIn;
      prodI  <= xReg * cosReg;
      prodQ  <= xReg * sinReg;
      iOut   <= roundSat(prodI);
      qOut   <= roundSat(prodQ);
    end
  end

  assert_zero_on_commit_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.zeroAcc |=> phaseOut == '0);

  assert_table_symmetric_R8: assert property (@(posedge clk) disable iff (rst)
    sinReg != {1'b1, {(AMP_W-1){1'b0}}} && cosReg != {1'b1, {(AMP_W-1){1'b0}}});

  assert_no_neg_full_scale_R9: assert property (@(posedge clk) disable iff (rst)
    iOut != {1'b1, {(OUT_W-1){1'b0}}} && qOut != {1'b1, {(OUT_W-1){1'b0}}});
endmodule

// File: rtl/quad_nco_mixer.sv
module quad_nco_mixer
  import nco_mix_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int PHASE_W    = 24,
  parameter int LUT_ADDR_W = 10,
  parameter int AMP_W      = 19,
  parameter int IN_W       = 16,
  parameter int OUT_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freqWrEn,
  input  logic [FREQ_W-1:0]  freqWrData,
  input  logic               freqXfer,
  input  logic               syncIn,
  input  logic               syncLoadEn,
  input  logic               zeroOnLoad,
  input  logic [IN_W-1:0]    sampleIn,
  output logic [PHASE_W-1:0] phaseOut,
  output logic [OUT_W-1:0]   iOut,
  output logic [OUT_W-1:0]   qOut
);
  logic [FREQ_W-1:0] activeFreq;
  ncoStrobe_t        strobe;

  nco_mix_ctrl #(.FREQ_W(FREQ_W)) u_ctrl (
    .clk(clk), .rst(rst), .freqWrEn(freqWrEn), .freqWrData(freqWrData),
    .freqXfer(freqXfer), .syncIn(syncIn), .syncLoadEn(syncLoadEn),
    .zeroOnLoad(zeroOnLoad), .activeFreq(activeFreq), .strobe(strobe)
  );

  nco_mix_datapath #(
    .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .LUT_ADDR_W(LUT_ADDR_W),
    .AMP_W(AMP_W), .IN_W(IN_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .activeFreq(activeFreq), .strobe(strobe),
    .sampleIn(sampleIn), .phaseOut(phaseOut), .iOut(iOut), .qOut(qOut)
  );
endmodule

// File: tb/sim_quad_nco_mixer.sv
module sim_quad_nco_mixer;
  localparam int LW = 6;
  localparam int N  = 1 << LW;

  logic        clk = 1'b0;
  logic        rst;
  logic        freqWrEn, freqXfer, syncIn, syncLoadEn, zeroOnLoad;
  logic [31:0] freqWrData;
  logic [15:0] sampleIn;
  logic [23:0] phaseOut;
  logic [15:0] iOut, qOut;

  always #10 clk = ~clk;  // 50 MHz

  quad_nco_mixer #(.LUT_ADDR_W(LW)) u0 (
    .clk(clk), .rst(rst), .freqWrEn(freqWrEn), .freqWrData(freqWrData),
    .freqXfer(freqXfer), .syncIn(syncIn), .syncLoadEn(syncLoadEn),
    .zeroOnLoad(zeroOnLoad), .sampleIn(sampleIn), .phaseOut(phaseOut),
    .iOut(iOut), .qOut(qOut)
  );

  int nRun = 0, nFail = 0;
  bit trackOn = 1'b0;
  bit done = 1'b0;

  task automatic check(input string tag, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected table value (R8): round-half-away of 262143*sin(2*pi*a/N)
  function automatic longint lutSin(input int a);
    real ang, v;
    ang = 6.283185307179586 * a / N;
    v = 262143.0 * $sin(ang);
    return longint'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
  endfunction

  // expected output scaling (R9)
  function automatic longint rs(input longint p);
    longint s;
    s = (p + 131072) >>> 18;
    if (s > 32767) return 32767;
    if (s < -32767) return -32767;
    return s;
  endfunction

  // arithmetic reference built from the requirements
  logic [31:0] mAcc, mHold, mAct;
  longint mX, mC, mS, mPI, mPQ, mI, mQ;
  always @(posedge clk) begin
    int a;
    logic xf;
    if (rst) begin
      mAcc <= 0; mHold <= 0; mAct <= 0;
      mX <= 0; mC <= 0; mS <= 0; mPI <= 0; mPQ <= 0; mI <= 0; mQ <= 0;
    end else begin
      a = int'(mAcc[31:32-LW]);
      mI  <= rs(mPI);
      mQ  <= rs(mPQ);
      mPI <= mX * mC;
      mPQ <= mX * mS;
      mX  <= longint'($signed(sampleIn));
      mS  <= lutSin(a);
      mC  <= lutSin((a + N / 4) % N);
      xf = freqXfer | (syncIn & syncLoadEn);
      if (xf) mAct <= mHold;
      if (freqWrEn) mHold <= freqWrData;
      mAcc <= (xf && zeroOnLoad) ? 32'd0 : mAcc + mAct;
    end
  end

  always @(negedge clk) begin
    if (trackOn) begin
      check("R7 phase word", longint'(phaseOut), longint'(mAcc[31:8]));
      check("R9 R10 in-phase", longint'($signed(iOut)), mI);
      check("R9 R10 quadrature", longint'($signed(qOut)), mQ);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic writeHold(input logic [31:0] w);
    freqWrEn = 1'b1; freqWrData = w;
    @(negedge clk);
    freqWrEn = 1'b0;
  endtask

  // measure the phase step between two consecutive cycles
  task automatic stepNow(output longint d);
    logic [23:0] p0;
    p0 = phaseOut;
    @(negedge clk);
    d = longint'(24'(phaseOut - p0));
  endtask

  initial begin
    longint d, pb;
    int lcg;
    rst = 1'b1; freqWrEn = 0; freqWrData = 0; freqXfer = 0; syncIn = 0;
    syncLoadEn = 0; zeroOnLoad = 0; sampleIn = 0;
    repeat (3) @(negedge clk);
    check("R1 reset phase", longint'(phaseOut), 0);
    check("R1 reset I", longint'(iOut), 0);
    check("R1 reset Q", longint'(qOut), 0);
    rst = 1'b0;
    trackOn = 1'b1;
    @(negedge clk);
    check("R1 idle phase", longint'(phaseOut), 0);

    // R2: staged word does not run
    writeHold(32'h0400_0000);
    repeat (4) @(negedge clk);
    check("R2 no commit phase", longint'(phaseOut), 0);

    // R3: host commit
    freqXfer = 1'b1; @(negedge clk); freqXfer = 1'b0;
    stepNow(d);
    check("R3 commit step", d, 64'h4_0000);
    // R3: write and commit together take the older pending word
    freqWrEn = 1'b1; freqWrData = 32'h0020_0000; freqXfer = 1'b1;
    @(negedge clk);
    freqWrEn = 1'b0; freqXfer = 1'b0;
    stepNow(d);
    check("R3 same-cycle write", d, 64'h4_0000);
    freqXfer = 1'b1; @(negedge clk); freqXfer = 1'b0;
    stepNow(d);
    check("R3 later commit", d, 64'h2000);

    // R4: masked sync ignored, enabled sync commits
    writeHold(32'h0008_0000);
    syncIn = 1'b1; @(negedge clk); syncIn = 1'b0;
    stepNow(d);
    check("R4 masked sync", d, 64'h2000);
    syncLoadEn = 1'b1;
    syncIn = 1'b1; @(negedge clk); syncIn = 1'b0;
    stepNow(d);
    check("R4 enabled sync", d, 64'h800);

    // R5: both commit sources at once
    writeHold(32'h0100_0000);
    syncIn = 1'b1; freqXfer = 1'b1; @(negedge clk); syncIn = 1'b0; freqXfer = 1'b0;
    stepNow(d);
    check("R5 joint commit", d, 64'h1_0000);
    syncLoadEn = 1'b0;

    // R6: commit without phase reset continues
    writeHold(32'h0030_0000);
    pb = longint'(phaseOut);
    freqXfer = 1'b1; @(negedge clk); freqXfer = 1'b0;
    check("R6 continue", longint'(phaseOut), (pb + 64'h1_0000) & 64'hFF_FFFF);
    // R6: commit with phase reset
    writeHold(32'h0400_0000);
    zeroOnLoad = 1'b1;
    freqXfer = 1'b1; @(negedge clk); freqXfer = 1'b0;
    check("R6 zeroed", longint'(phaseOut), 0);
    @(negedge clk);
    check("R6 new step", longint'(phaseOut), 64'h4_0000);

    // R8 R9 R10: exhaustive phase sweep, one table entry per clock
    for (int pat = 0; pat < 6; pat++) begin
      for (int k = 0; k < 2 * N; k++) begin
        case (pat)
          0: sampleIn = 16'h7FFF;
          1: sampleIn = 16'h8000;
          2: sampleIn = 16'(k * 1021 - 32768);
          3: sampleIn = (k % 2 == 0) ? 16'h7FFF : 16'h8000;
          4: sampleIn = (k % 2 == 0) ? 16'h0001 : 16'hFFFF;
          default: sampleIn = 16'(k * 37 - 2000);
        endcase
        @(negedge clk);
      end
    end

    // R9: saturation at phase 0 (cos = +262143, sin = 0)
    writeHold(32'h0);
    freqXfer = 1'b1; @(negedge clk); freqXfer = 1'b0;
    sampleIn = 16'h8000;
    repeat (3) @(negedge clk);
    check("R9 negative clamp I", longint'($signed(iOut)), -32767);
    check("R9 zero Q", longint'($signed(qOut)), 0);
    sampleIn = 16'h7FFF;
    repeat (3) @(negedge clk);
    check("R9 positive I", longint'($signed(iOut)), 32767);

    // R10: isolated impulse latency
    sampleIn = 16'h0;
    repeat (4) @(negedge clk);
    sampleIn = 16'd20000;
    @(negedge clk);
    sampleIn = 16'h0;
    check("R10 lat 1", longint'($signed(iOut)), 0);
    @(negedge clk);
    check("R10 lat 2", longint'($signed(iOut)), 0);
    @(negedge clk);
    check("R10 lat 3", longint'($signed(iOut)), 20000);
    @(negedge clk);
    check("R10 lat 4", longint'($signed(iOut)), 0);

    // R8 R9: irregular frequency, pseudo-random samples
    zeroOnLoad = 1'b0;
    writeHold(32'h0123_4567);
    freqXfer = 1'b1; @(negedge clk); freqXfer = 1'b0;
    lcg = 12345;
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 1103515245 + 12345;
      sampleIn = 16'(lcg >>> 8);
      @(negedge clk);
    end

    done = 1'b1;
    summary();
  end
endmodule